// File: doc/BRIEF.md
# Three-Level Phase-Disposed Sine PWM Gate Generator

This block drives the twelve switches of a three-phase, three-level clamped-midpoint inverter. A phase accumulator advances by a tuning word on every clock. Three sine references are taken from it at offsets of one third of a turn. The sine values are computed from the phase index, not read from a stored table. Each reference is scaled by a modulation index and clipped to the carrier peak.

Two triangular carriers share one up/down counter, so they always have the same frequency, amplitude and phase. The upper carrier spans 0 to +A. The lower carrier spans -A to 0. Each reference is compared with both carriers. The outer upper switch follows "reference above upper carrier" and the inner upper switch follows "reference above lower carrier". Each lower switch is the complement of its upper partner, with a programmable dead time inserted between them.

Every phase also reports a signed level code, and the sum of the three codes is output as a common-mode indicator. All inputs are plain control words sampled on every clock. No data stream enters or leaves the block, so there is no handshake and no back-pressure.

Top module: `spwm3l_gen`

## Requirements
- R1: Both carriers come from one counter that steps by exactly one per clock: 0, 1, …, A, A-1, …, 1, 0, …, so a carrier period is 2A cycles. The upper carrier is the count and the lower carrier is the count minus A.
- R2: The phase accumulator adds `ftw_i` every clock. Phases a, b and c read it at offsets of 0, 1/3 and 2/3 of its range. With a tuning word of 0, reference a is exactly zero, reference b is positive and reference c is negative. With a nonzero word, every phase reaches both +1 and -1 within one reference period.
- R3: A reference equals the sine value times `mod_idx_i` (unsigned, 7 fraction bits) and is saturated to the range ±A. At index 64 (one half), the fraction of a carrier period that phase b spends at +1 is close to 0.5·sin(120°)·2047/A.
- R4: The comparisons are registered. The outer command is reference > upper carrier, and the inner command is reference > lower carrier.
- R5: `level_o[2p+1:2p]` is a two's-complement code: 01 (+1) when both upper switches are commanded on, 00 (0) when only the inner one is, and 11 (-1) when neither is. The code 10 never appears. Phase a uses p=0, b uses p=1 and c uses p=2.
- R6: `cm_sum_o` is the 3-bit two's-complement sum of the three level codes, in the range -3 to +3.
- R7: Gate layout for phase p: bit 4p is outer upper, 4p+1 is inner upper, 4p+2 is outer lower and 4p+3 is inner lower. Each lower gate carries the complement of its upper partner's command.
- R8: After each change of a pair's command, both gates of that pair stay off for `dead_i` cycles. With a dead time of 0 the pair is strictly complementary. A one-cycle dip in the command keeps the pair off for `dead_i`+1 cycles.
- R9: The two gates of a pair are never on together, and the outer upper gate is never on while the inner lower gate of the same leg is on.
- R10: While reset is asserted, all gates are off, every level code reads 11 (-1) and `cm_sum_o` reads 101 (-3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ftw_i | input | ACC_W | Phase increment per clock |
| car_peak_i | input | CAR_W | Carrier peak A; the carrier period is 2A cycles |
| mod_idx_i | input | MI_W | Modulation index, unsigned with 7 fraction bits |
| dead_i | input | DT_W | Dead time in clock cycles |
| gate_o | output | 12 | Gate commands, four per leg (layout in R7) |
| level_o | output | 6 | Signed level code per phase (encoding in R5) |
| cm_sum_o | output | 3 | Signed sum of the three level codes |

## Verification
The checker watches four properties on every clock: no pair ever shoots through, the clamping order between the outer upper and inner lower gates, a gap before a gate turns on whenever the dead time is nonzero, and level and sum codes that stay legal. It also checks that the carrier moves by exactly one per clock and that each reference stays inside ±A. Other behaviours only show up across a whole carrier or reference period, so the bench scenarios have to measure them. These are the duty split between levels, clipping under overmodulation, the 120-degree spacing of the phases, the exact length of a dead-time gap, and the effect of the modulation index on duty.

// File: rtl/spwm3l_pkg.sv
package spwm3l_pkg;

  localparam int NPH = 3;

  // gate bit offsets inside one leg
  localparam int G_OUT_HI = 0;
  localparam int G_IN_HI  = 1;
  localparam int G_OUT_LO = 2;
  localparam int G_IN_LO  = 3;

  typedef enum logic [1:0] {
    LVL_NEG = 2'b11,
    LVL_MID = 2'b00,
    LVL_POS = 2'b01
  } lvl_e;

  function automatic lvl_e lvl_encode(input logic outer_on, input logic inner_on);
    if (outer_on && inner_on) return LVL_POS;
    else if (inner_on)        return LVL_MID;
    else                      return LVL_NEG;
  endfunction

endpackage

// File: rtl/spwm3l_carrier.sv
module spwm3l_carrier #(
  parameter int CAR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CAR_W-1:0] peak_i,
  output logic [CAR_W-1:0] cnt_o
);

  localparam logic [CAR_W-1:0] ONE = CAR_W'(1);

  logic             up_q;
  logic [CAR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (peak_i == '0) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= peak_i) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else begin
      if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/spwm3l_ref.sv
module spwm3l_ref #(
  parameter int               ACC_W  = 16,
  parameter int               SIN_AW = 8,
  parameter int               SIN_W  = 12,
  parameter int               CAR_W  = 12,
  parameter int               MI_W   = 8,
  parameter logic [ACC_W-1:0] OFFSET = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ACC_W-1:0]        acc_i,
  input  logic [MI_W-1:0]         mi_i,
  input  logic [CAR_W-1:0]        peak_i,
  output logic signed [CAR_W:0]   ref_o
);

  localparam int H      = SIN_AW - 1;        // bits inside a half wave
  localparam int SQ_W   = 2 * H + 2;
  localparam int BIG_W  = SQ_W + SIN_W;
  localparam int FS     = (1 << (SIN_W - 1)) - 1;
  localparam int PW     = SIN_W + MI_W + 1;
  localparam int FRAC   = MI_W - 1;

  logic [ACC_W-1:0]         ph;
  logic [SIN_AW-1:0]        idx;
  logic [SQ_W-1:0]          sq;
  logic [BIG_W-1:0]         big;
  logic [BIG_W-1:0]         shifted;
  logic signed [SIN_W-1:0]  sin_s;
  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     scaled;
  logic signed [PW-1:0]     pk;
  logic signed [PW-1:0]     clipped;

  assign ph  = acc_i + OFFSET;
  assign idx = ph[ACC_W-1 -: SIN_AW];

  // half wave approximated by 4x(1-x), full scale FS
  always_comb begin
    sq      = SQ_W'(idx[H-1:0]) * (SQ_W'(1 << H) - SQ_W'(idx[H-1:0]));
    big     = BIG_W'(sq) * BIG_W'(FS);
    shifted = big >> (2 * H - 2);
    if (idx[H]) sin_s = -$signed({1'b0, shifted[SIN_W-2:0]});
    else        sin_s =  $signed({1'b0, shifted[SIN_W-2:0]});
  end

  always_comb begin
    prod   = PW'(sin_s) * $signed(PW'(mi_i));
    scaled = prod >>> FRAC;
    pk     = $signed(PW'(peak_i));
    if (scaled > pk)       clipped = pk;
    else if (scaled < -pk) clipped = -pk;
    else                   clipped = scaled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_o <= '0;
    else         ref_o <= clipped[CAR_W:0];
  end

endmodule

// File: rtl/spwm3l_deadtime.sv
module spwm3l_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hi_o,
  output logic            lo_o
);

  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic            prev_q;
  logic            arm_q;
  logic [DT_W-1:0] cnt_q;
  logic            settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      arm_q  <= 1'b1;
      prev_q <= cmd_i;
      if (cmd_i != prev_q)  cnt_q <= '0;
      else if (cnt_q != '1) cnt_q <= cnt_q + ONE;
    end
  end

  assign settled = arm_q && (cnt_q >= dt_i);
  assign hi_o    = settled && prev_q;
  assign lo_o    = settled && !prev_q;

endmodule

// File: rtl/spwm3l_gen.sv
module spwm3l_gen
  import spwm3l_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int SIN_AW = 8,
  parameter int SIN_W  = 12,
  parameter int CAR_W  = 12,
  parameter int MI_W   = 8,
  parameter int DT_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W-1:0]   ftw_i,
  input  logic [CAR_W-1:0]   car_peak_i,
  input  logic [MI_W-1:0]    mod_idx_i,
  input  logic [DT_W-1:0]    dead_i,
  output logic [4*NPH-1:0]   gate_o,
  output logic [2*NPH-1:0]   level_o,
  output logic [2:0]         cm_sum_o
);

  localparam int RW = CAR_W + 1;   // reference width
  localparam int CW = CAR_W + 2;   // comparison width

  logic [ACC_W-1:0]      acc_q;
  logic [CAR_W-1:0]      car_cnt;
  logic [NPH*RW-1:0]     ref_pk;
  logic signed [CW-1:0]  up_s;
  logic signed [CW-1:0]  low_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + ftw_i;
  end

  spwm3l_carrier #(.CAR_W(CAR_W)) u_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .peak_i (car_peak_i),
    .cnt_o  (car_cnt)
  );

  assign up_s  = $signed({2'b00, car_cnt});
  assign low_s = up_s - $signed({2'b00, car_peak_i});

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    localparam logic [ACC_W-1:0] OFF = ACC_W'(((64'd1 << ACC_W) * 64'(p)) / 64'd3);

    logic signed [RW-1:0] ref_q;
    logic                 out_cmd_q;
    logic                 in_cmd_q;

    spwm3l_ref #(
      .ACC_W (ACC_W), .SIN_AW(SIN_AW), .SIN_W(SIN_W),
      .CAR_W (CAR_W), .MI_W  (MI_W),   .OFFSET(OFF)
    ) u_ref (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (acc_q),
      .mi_i   (mod_idx_i),
      .peak_i (car_peak_i),
      .ref_o  (ref_q)
    );

    assign ref_pk[p*RW +: RW] = ref_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_cmd_q <= 1'b0;
        in_cmd_q  <= 1'b0;
      end else begin
        out_cmd_q <= $signed({ref_q[RW-1], ref_q}) > up_s;
        in_cmd_q  <= $signed({ref_q[RW-1], ref_q}) > low_s;
      end
    end

    spwm3l_deadtime #(.DT_W(DT_W)) u_dt_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (out_cmd_q),
      .dt_i   (dead_i),
      .hi_o   (gate_o[4*p + G_OUT_HI]),
      .lo_o   (gate_o[4*p + G_OUT_LO])
    );

    spwm3l_deadtime #(.DT_W(DT_W)) u_dt_in (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (in_cmd_q),
      .dt_i   (dead_i),
      .hi_o   (gate_o[4*p + G_IN_HI]),
      .lo_o   (gate_o[4*p + G_IN_LO])
    );

    assign level_o[2*p +: 2] = lvl_encode(out_cmd_q, in_cmd_q);
  end

  always_comb begin
    cm_sum_o = '0;
    for (int p = 0; p < NPH; p++) begin
      cm_sum_o = cm_sum_o + {level_o[2*p+1], level_o[2*p +: 2]};
    end
  end

endmodule

// File: rtl/spwm3l_chk.sv
module spwm3l_chk #(
  parameter int CAR_W = 12,
  parameter int DT_W  = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [11:0]            gate_i,
  input logic [5:0]             level_i,
  input logic [2:0]             cm_i,
  input logic [DT_W-1:0]        dead_i,
  input logic [CAR_W-1:0]       peak_i,
  input logic [CAR_W-1:0]       cnt_i,
  input logic [3*(CAR_W+1)-1:0] ref_pk_i
);

  AST_CARRIER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && peak_i != '0 && $past(peak_i) != '0) |->
      (cnt_i == $past(cnt_i) + CAR_W'(1) || cnt_i == $past(cnt_i) - CAR_W'(1))); // R1

  AST_CM_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_i != 3'b100); // R6

  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic signed [CAR_W:0] r;
    assign r = $signed(ref_pk_i[p*(CAR_W+1) +: CAR_W+1]);

    AST_REF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $stable(peak_i)) |->
        (r <= $signed({1'b0, peak_i}) && r >= -$signed({1'b0, peak_i}))); // R3

    AST_LEVEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_i[2*p +: 2] != 2'b10); // R5

    AST_CLAMP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_i[4*p] |-> !gate_i[4*p+3]); // R9

    for (genvar k = 0; k < 2; k++) begin : g_pair
      AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(gate_i[4*p+k] && gate_i[4*p+2+k])); // R9

      AST_DEAD_GAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && dead_i != '0 && $past(dead_i) != '0 &&
         gate_i[4*p+k] && !$past(gate_i[4*p+k])) |-> !$past(gate_i[4*p+2+k])); // R8

      AST_DEAD_GAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && dead_i != '0 && $past(dead_i) != '0 &&
         gate_i[4*p+2+k] && !$past(gate_i[4*p+2+k])) |-> !$past(gate_i[4*p+k])); // R8
    end
  end

endmodule

bind spwm3l_gen spwm3l_chk #(.CAR_W(CAR_W), .DT_W(DT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gate_i   (gate_o),
  .level_i  (level_o),
  .cm_i     (cm_sum_o),
  .dead_i   (dead_i),
  .peak_i   (car_peak_i),
  .cnt_i    (car_cnt),
  .ref_pk_i (ref_pk)
);

// File: tb/spwm3l_gen_bench.sv
`timescale 1ns/1ps
module spwm3l_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ftw = '0;
  logic [11:0] peak = 12'd10;
  logic [7:0]  mi = '0;
  logic [5:0]  dead = '0;
  logic [11:0] gate;
  logic [5:0]  level;
  logic [2:0]  cm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spwm3l_gen u_spwm3l_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ftw_i      (ftw),
    .car_peak_i (peak),
    .mod_idx_i  (mi),
    .dead_i     (dead),
    .gate_o     (gate),
    .level_o    (level),
    .cm_sum_o   (cm)
  );

  // vector table: mi, peak, dead, expected counts over one carrier period
  localparam int NV = 4;
  localparam int V_MI[NV]    = '{0, 255, 255, 0};
  localparam int V_PK[NV]    = '{10, 10, 50, 7};
  localparam int V_DT[NV]    = '{0, 3, 0, 5};
  localparam int E_POS[NV][3] = '{'{0,0,0}, '{0,19,0}, '{0,99,0}, '{0,0,0}};
  localparam int E_MID[NV][3] = '{'{19,19,19}, '{19,1,0}, '{99,1,0}, '{13,13,13}};
  localparam int E_NEG[NV][3] = '{'{1,1,1}, '{1,0,20}, '{1,0,100}, '{1,1,1}};
  localparam int E_OFF[NV]   = '{0, 4, 0, 6};

  int c_pos[3], c_mid[3], c_neg[3];
  int sum_err, off_a, shoot, olo_a;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int dec(input logic [1:0] c);
    case (c)
      2'b01:   return 1;
      2'b00:   return 0;
      2'b11:   return -1;
      default: return 99;
    endcase
  endfunction

  task automatic measure(input int win);
    for (int p = 0; p < 3; p++) begin
      c_pos[p] = 0; c_mid[p] = 0; c_neg[p] = 0;
    end
    sum_err = 0; off_a = 0; shoot = 0; olo_a = 0;
    repeat (win) begin
      int tot;
      @(negedge clk);
      tot = 0;
      for (int p = 0; p < 3; p++) begin
        int v;
        v = dec(level[2*p +: 2]);
        tot += v;
        if (v == 1) c_pos[p]++;
        else if (v == 0) c_mid[p]++;
        else if (v == -1) c_neg[p]++;
        for (int k = 0; k < 2; k++)
          if (gate[4*p+k] && gate[4*p+2+k]) shoot++;
      end
      if (int'($signed(cm)) != tot) sum_err++;
      if (!gate[1] && !gate[3]) off_a++;
      if (gate[2]) olo_a++;
    end
  endtask

  task automatic configure(input int m, input int pk, input int d, input int f);
    @(negedge clk);
    mi = 8'(m); peak = 12'(pk); dead = 6'(d); ftw = 16'(f);
    repeat (4 * pk + 40) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    chk({"R10 gates off ", tag}, int'(gate), 0);
    chk({"R10 levels -1 ", tag}, int'(level), 63);
    chk({"R10 sum -3 ", tag}, int'($signed(cm)), -3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check_reset_state("(start)");
    rst_n = 1'b1;

    // table walk: R1 R4 R5 carrier/compare/levels, R6 sum, R7 complement, R8 dead time, R9 no overlap
    for (int v = 0; v < NV; v++) begin
      configure(V_MI[v], V_PK[v], V_DT[v], 0);
      measure(2 * V_PK[v]);
      for (int p = 0; p < 3; p++) begin
        chk($sformatf("R1/R4/R5 vec%0d ph%0d +1 count", v, p), c_pos[p], E_POS[v][p]);
        chk($sformatf("R1/R4/R5 vec%0d ph%0d 0 count", v, p), c_mid[p], E_MID[v][p]);
        chk($sformatf("R1/R4/R5 vec%0d ph%0d -1 count", v, p), c_neg[p], E_NEG[v][p]);
      end
      chk($sformatf("R6 vec%0d sum mismatches", v), sum_err, 0);
      chk($sformatf("R8 vec%0d inner pair a off cycles", v), off_a, E_OFF[v]);
      chk($sformatf("R7 vec%0d outer lower a on cycles", v), olo_a, 2 * V_PK[v]);
      chk($sformatf("R9 vec%0d overlap cycles", v), shoot, 0);
    end

    // R3: half modulation index, duty of phases b and c near ideal
    configure(64, 2000, 0, 0);
    measure(4000);
    chk_rng("R3 phase b +1 duty", c_pos[1], 1653, 1893);
    chk_rng("R3 phase c -1 duty", c_neg[2], 1653, 1893);
    chk("R2 phase a zero ref never +1", c_pos[0], 0);

    // R2: rotating references, every phase swings both ways in one period
    configure(127, 20, 0, 33);
    measure(2000);
    for (int p = 0; p < 3; p++) begin
      chk($sformatf("R2 ph%0d reaches +1", p), int'(c_pos[p] > 0), 1);
      chk($sformatf("R2 ph%0d reaches -1", p), int'(c_neg[p] > 0), 1);
    end

    // R10: reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("(mid-run)");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule